// File: doc/BRIEF.md
# Direction-Switchable Serial Channel with Buffer Status

This block is one serial data channel that either sends or receives words over a one-bit serial line, depending on a single direction input. A small word buffer sits between the serial shift register and a host-side register interface. When the channel transmits, the host writes words into the buffer and the shift register drains them. When it receives, the shift register fills the buffer and the host reads words out. Serial timing comes from a bit-enable strobe (`bit_tick`) in the system clock domain, so one clock serves both the host side and the serial side.

Word boundaries come from one of two framing modes. In the framed mode, a frame-sync pulse that arrives together with a bit strobe starts each word. In the free-running mode, words follow each other back to back. The host sees the buffer fill level as a two-bit code. A sticky error flag reports transmit underflow or receive overflow. On receive overflow the oldest buffered word is discarded and the new word is kept. Changing the direction or the framing mode flushes the channel.

Top module: `spchan_top`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `buf_stat` is 2'b00, `err_flag` is 0 and `sd_out` is 0.
- R2: `buf_stat` encodes the number of buffered words as 2'b00 for none, 2'b10 for one (partially full) and 2'b11 for two (full). The code 2'b01 never appears. A host read on an empty buffer changes nothing.
- R3: With `dir_tx`=0 the channel receives. It samples `sd_in` MSB first only in cycles where `bit_tick`=1. After the WORD_W-th bit it appends the word to the buffer. `rd_data` shows the oldest word, and `rd_en` removes it. `wr_en` has no effect.
- R4: With `dir_tx`=1 the channel transmits. A host write is stored if the buffer is not full, and is dropped if it is full. At each word start the oldest word is removed and shifted out MSB first, one bit per `bit_tick`. A bit appears on `sd_out` after the clock edge of its tick. `rd_en` has no effect.
- R5: With `fs_req`=1, a word starts on a `bit_tick` cycle with `fs_in`=1. A new frame-sync pulse during a word abandons that word and starts a new one, and the partial word is never stored. Ticks that come after a word and carry no frame-sync move no data, and `sd_out` is 0 during them. `fs_in` is ignored when `bit_tick`=0.
- R6: With `fs_req`=0, words run back to back every WORD_W ticks. The first word starts on the first tick after reset or after a mode change. `fs_in` is ignored.
- R7: In transmit, a word start with an empty buffer sets `err_flag` and removes nothing. That word repeats the previously sent word, or all zeros if no word has been sent since the last flush.
- R8: In framed receive, a frame-sync tick while the buffer holds two words sets `err_flag`.
- R9: In free-running receive, completing a word while the buffer is full, with no host read in the same cycle, sets `err_flag`.
- R10: A word received into a full buffer discards the oldest word and keeps the new one. The buffer stays full.
- R11: `err_flag` stays set until a cycle with `err_clr`=1, and reads 0 from the next cycle on. If an error event falls in the same cycle as `err_clr`, the flag stays set.
- R12: A cycle in which `dir_tx` or `fs_req` differs from its value in the previous cycle empties the buffer, clears `err_flag`, restarts framing and drops all other activity of that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_tx | input | 1 | Direction: 1 transmit, 0 receive |
| fs_req | input | 1 | Framing: 1 frame-sync started words, 0 back-to-back words |
| bit_tick | input | 1 | Serial bit enable, one cycle per bit |
| fs_in | input | 1 | Frame-sync pulse, sampled with `bit_tick` |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| wr_en | input | 1 | Host write strobe (transmit only) |
| wr_data | input | WORD_W | Host write word |
| rd_en | input | 1 | Host read strobe (receive only) |
| rd_data | output | WORD_W | Oldest buffered word |
| err_clr | input | 1 | Clears the sticky error flag |
| buf_stat | output | 2 | Buffer fill code |
| err_flag | output | 1 | Sticky underflow/overflow flag |

## Verification
The bench goes after the overflow path first. A design that drops the new word instead of the oldest one, or that grows past two entries, returns the wrong word on the next reads. It also checks that a framed receive raises the flag at the frame-sync tick rather than at the end of the word, and that an aborted partial word never lands in the buffer; a design that stored the partial word would miscount the fill level. On underflow it checks that the previous word is repeated and the buffer is not popped, since an extra pop would make the status code go wrong. Finally it checks that a direction or framing change flushes a full buffer and a set flag, that `fs_in`, `sd_in` and host strobes of the wrong direction are ignored, and that random word streams in both directions match a queue model.

// File: rtl/spchan_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial channel.
// Assumes: buffer fill is reported as a two-bit code; the value 2'b01 is unused.
package spchan_pkg;

    typedef enum logic [1:0] {
        FILL_NONE = 2'b00,
        FILL_PART = 2'b10,
        FILL_FULL = 2'b11
    } fill_code_e;

endpackage

// File: rtl/spchan_fifo.sv
`timescale 1ns/1ps
// Word buffer between the shift register and the host.
// Circular storage with read/write pointers and an occupancy counter.
// When ovw_en is set, a push into a full buffer replaces the oldest word.
// Assumes: flush has priority over every other request in its cycle.
module spchan_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           push,
    input  logic                           pop,
    input  logic                           ovw_en,
    input  logic [W-1:0]                   din,
    output logic [W-1:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rptr, wptr;
    logic          pop_ok, wr_fire, drop;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign wr_fire = push && (!full || pop_ok || ovw_en);
    assign drop    = wr_fire && full && !pop_ok;
    assign head    = mem[rptr];

    // One register per entry, written when the write pointer selects it.
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[e] <= '0;
            else if (!flush && wr_fire && wptr == PW'(e))
                mem[e] <= din;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (wr_fire)
                wptr <= step_ptr(wptr);
            if (pop_ok || drop)
                rptr <= step_ptr(rptr);
            count <= count + CW'(wr_fire && !drop) - CW'(pop_ok);
        end
    end

endmodule

// File: rtl/spchan_shifter.sv
`timescale 1ns/1ps
// Serial shift register and framing for the channel.
// Counts bits within a word. In transmit it loads a word at each word
// start; in receive it assembles a word and offers it after the last bit.
// It also reports underflow and overflow events.
// Assumes: all serial activity happens in cycles with bit_tick high, and
// flush is high for exactly the cycle in which a mode input changes.
module spchan_shifter #(
    parameter int W           = 8,
    parameter int REPEAT_LAST = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         tx_mode,
    input  logic         fs_req,
    input  logic         bit_tick,
    input  logic         fs_in,
    input  logic         sd_in,
    input  logic         buf_empty,
    input  logic         buf_full,
    input  logic [W-1:0] buf_head,
    input  logic         host_pop,
    output logic         take_word,
    output logic         give_word,
    output logic [W-1:0] rx_word,
    output logic         err_evt,
    output logic         sd_out
);
    localparam int BW = $clog2(W);

    logic [W-1:0]  sreg;
    logic [BW-1:0] pos;
    logic          busy;
    logic          start, last_bit;
    logic [W-1:0]  fill, load_word;

    // Word start: a frame-sync tick, or any tick while idle in free-running mode.
    assign start    = bit_tick && (fs_req ? fs_in : !busy);
    // The tick that handles the final bit of the current word.
    assign last_bit = bit_tick && busy && !start && (pos == BW'(W - 1));

    assign take_word = tx_mode && start && !buf_empty;
    assign give_word = !tx_mode && last_bit;
    assign rx_word   = {sreg[W-2:0], sd_in};
    assign load_word = buf_empty ? fill : buf_head;

    // Underflow in transmit; overflow at frame-sync or at completion in receive.
    always_comb begin
        if (tx_mode)
            err_evt = start && buf_empty;
        else if (fs_req)
            err_evt = start && buf_full;
        else
            err_evt = last_bit && buf_full && !host_pop;
    end

    // Word used on underflow: the last word sent, or all zeros.
    if (REPEAT_LAST != 0) begin : g_repeat
        logic [W-1:0] last_sent;
        // Remember each word loaded for transmission.
        always_ff @(posedge clk) begin
            if (!rst_n || flush)
                last_sent <= '0;
            else if (tx_mode && start)
                last_sent <= load_word;
        end
        assign fill = last_sent;
    end else begin : g_zero
        assign fill = '0;
    end

    // Bit counter, shift register and serial output.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            busy   <= 1'b0;
            pos    <= '0;
            sreg   <= '0;
            sd_out <= 1'b0;
        end else if (bit_tick) begin
            if (start) begin
                busy <= 1'b1;
                pos  <= BW'(1);
                if (tx_mode) begin
                    sd_out <= load_word[W-1];
                    sreg   <= {load_word[W-2:0], 1'b0};
                end else begin
                    sreg <= {{(W-1){1'b0}}, sd_in};
                end
            end else if (busy) begin
                if (pos == BW'(W - 1)) begin
                    busy <= 1'b0;
                    pos  <= '0;
                end else begin
                    pos <= pos + BW'(1);
                end
                if (tx_mode) begin
                    sd_out <= sreg[W-1];
                    sreg   <= {sreg[W-2:0], 1'b0};
                end else begin
                    sreg <= {sreg[W-2:0], sd_in};
                end
            end else begin
                sd_out <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spchan_status.sv
`timescale 1ns/1ps
// Sticky error flag and fill-code encoder.
// Assumes: an error event wins over a clear in the same cycle; flush wins over both.
module spchan_status #(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       err_evt,
    input  logic                       err_clr,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       err_flag,
    output logic [1:0]                 buf_stat
);
    import spchan_pkg::*;
    localparam int CW = $clog2(DEPTH + 1);

    fill_code_e code;

    // Map occupancy to the two-bit fill code.
    always_comb begin
        if (count == '0)
            code = FILL_NONE;
        else if (count == CW'(DEPTH))
            code = FILL_FULL;
        else
            code = FILL_PART;
    end
    assign buf_stat = code;

    // Sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            err_flag <= 1'b0;
        else if (err_evt)
            err_flag <= 1'b1;
        else if (err_clr)
            err_flag <= 1'b0;
    end

endmodule

// File: rtl/spchan_top.sv
`timescale 1ns/1ps
// Direction-switchable serial channel with buffer status.
// Connects the word buffer, the shifter and the status logic. The direction
// input decides which side fills the buffer and which side drains it.
// Assumes: bit_tick, fs_in and sd_in are synchronous to clk; a change of
// dir_tx or fs_req flushes the channel for one cycle.
module spchan_top #(
    parameter int WORD_W      = 8,
    parameter int BUF_DEPTH   = 2,
    parameter int REPEAT_LAST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_tx,
    input  logic              fs_req,
    input  logic              bit_tick,
    input  logic              fs_in,
    input  logic              sd_in,
    output logic              sd_out,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              err_clr,
    output logic [1:0]        buf_stat,
    output logic              err_flag
);
    localparam int CW = $clog2(BUF_DEPTH + 1);

    logic              dir_q, fsreq_q, flush;
    logic              tick_g, wr_g, rd_g;
    logic              f_push, f_pop, f_empty, f_full;
    logic [CW-1:0]     f_count;
    logic [WORD_W-1:0] f_din, f_head;
    logic              s_take, s_give, s_err;
    logic [WORD_W-1:0] s_word;

    // Hold the previous mode inputs to detect a change.
    always_ff @(posedge clk) begin
        dir_q   <= dir_tx;
        fsreq_q <= fs_req;
    end

    assign flush  = (dir_tx != dir_q) || (fs_req != fsreq_q);
    assign tick_g = bit_tick && !flush;
    assign wr_g   = wr_en && dir_tx && !flush;
    assign rd_g   = rd_en && !dir_tx && !flush;

    assign f_push = dir_tx ? wr_g : s_give;
    assign f_pop  = dir_tx ? s_take : rd_g;
    assign f_din  = dir_tx ? wr_data : s_word;
    assign rd_data = f_head;

    spchan_fifo #(.W(WORD_W), .DEPTH(BUF_DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .push   (f_push),
        .pop    (f_pop),
        .ovw_en (!dir_tx),
        .din    (f_din),
        .head   (f_head),
        .count  (f_count),
        .empty  (f_empty),
        .full   (f_full)
    );

    spchan_shifter #(.W(WORD_W), .REPEAT_LAST(REPEAT_LAST)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .tx_mode   (dir_tx),
        .fs_req    (fs_req),
        .bit_tick  (tick_g),
        .fs_in     (fs_in),
        .sd_in     (sd_in),
        .buf_empty (f_empty),
        .buf_full  (f_full),
        .buf_head  (f_head),
        .host_pop  (rd_g),
        .take_word (s_take),
        .give_word (s_give),
        .rx_word   (s_word),
        .err_evt   (s_err),
        .sd_out    (sd_out)
    );

    spchan_status #(.DEPTH(BUF_DEPTH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .err_evt  (s_err),
        .err_clr  (err_clr),
        .count    (f_count),
        .err_flag (err_flag),
        .buf_stat (buf_stat)
    );

endmodule

// File: rtl/spchan_chk.sv
`timescale 1ns/1ps
// Port-level checker for spchan_top, attached by bind.
// Assumes: the top module's default two-entry buffer.
module spchan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dir_tx,
    input logic       fs_req,
    input logic       bit_tick,
    input logic       fs_in,
    input logic       wr_en,
    input logic       rd_en,
    input logic       err_clr,
    input logic       sd_out,
    input logic       err_flag,
    input logic [1:0] buf_stat
);
    // R2
    stat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_stat != 2'b01);

    // R2
    full_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_stat == 2'b11 && $stable(dir_tx) && $stable(fs_req)) |=> buf_stat != 2'b00);

    // R3
    rx_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_tx && wr_en && !rd_en && !bit_tick && $stable(dir_tx) && $stable(fs_req))
        |=> $stable(buf_stat));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && $stable(dir_tx) && $stable(fs_req)) |=> $stable(sd_out));

    // R7
    tx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && fs_in && fs_req && dir_tx && buf_stat == 2'b00
         && $stable(dir_tx) && $stable(fs_req)) |=> err_flag);

    // R8
    rx_overflow_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && fs_in && fs_req && !dir_tx && buf_stat == 2'b11
         && $stable(dir_tx) && $stable(fs_req)) |=> err_flag);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr && $stable(dir_tx) && $stable(fs_req)) |=> err_flag);

    // R12
    mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dir_tx) || !$stable(fs_req)) |=> (buf_stat == 2'b00 && !err_flag));

endmodule

bind spchan_top spchan_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_tx   (dir_tx),
    .fs_req   (fs_req),
    .bit_tick (bit_tick),
    .fs_in    (fs_in),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .err_clr  (err_clr),
    .sd_out   (sd_out),
    .err_flag (err_flag),
    .buf_stat (buf_stat)
);

// File: tb/test_spchan_top.sv
`timescale 1ns/1ps
module test_spchan_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, dir_tx, fs_req, bit_tick, fs_in, sd_in, sd_out;
    logic         wr_en, rd_en, err_clr, err_flag;
    logic [W-1:0] wr_data, rd_data;
    logic [1:0]   buf_stat;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    spchan_top #(.WORD_W(W), .BUF_DEPTH(2), .REPEAT_LAST(1)) i_spchan_top (
        .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .fs_req(fs_req),
        .bit_tick(bit_tick), .fs_in(fs_in), .sd_in(sd_in), .sd_out(sd_out),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .err_clr(err_clr), .buf_stat(buf_stat), .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] enc(input int n);
        if (n == 0) return 2'b00;
        if (n >= 2) return 2'b11;
        return 2'b10;
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // One serial bit, then an idle cycle that drives noise on fs_in and sd_in.
    task automatic bit_step(input logic fs, input logic d, output logic so);
        bit_tick = 1'b1; fs_in = fs; sd_in = d;
        cyc();
        so = sd_out;
        bit_tick = 1'b0; fs_in = 1'b1; sd_in = ~d;
        cyc();
        fs_in = 1'b0;
    endtask

    // fsm: 0 no frame-sync, 1 frame-sync on first bit, 2 random frame-sync
    function automatic logic fs_pick(input int fsm, input int i, input int from);
        if (fsm == 1) return (i == from);
        if (fsm == 2) return 1'($urandom % 2);
        return 1'b0;
    endfunction

    task automatic send_bits(input logic [W-1:0] w, input int fsm, input int from, input int to);
        logic so;
        for (int i = from; i <= to; i++)
            bit_step(fs_pick(fsm, i, from), w[W-1-i], so);
    endtask

    task automatic run_tx(input int fsm, output logic [W-1:0] got);
        logic so;
        for (int i = 0; i < W; i++) begin
            bit_step(fs_pick(fsm, i, 0), 1'($urandom % 2), so);
            got[W-1-i] = so;
        end
    endtask

    task automatic host_wr(input logic [W-1:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic host_rd(output logic [W-1:0] d);
        d = rd_data;
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        cyc();
        err_clr = 1'b0;
    endtask

    task automatic set_mode(input logic d, input logic f);
        dir_tx = d; fs_req = f;
        cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] a, b, c, d, x, y, z, got, exp, last;
        logic [W-1:0] mq[$];
        logic         merr;

        void'($urandom(32'h5EED));
        rst_n = 1'b0; dir_tx = 1'b0; fs_req = 1'b1; bit_tick = 1'b0; fs_in = 1'b0;
        sd_in = 1'b0; wr_en = 1'b0; rd_en = 1'b0; err_clr = 1'b0; wr_data = '0;
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 stat", 32'(buf_stat), 32'h0);
        chk("R1 err", 32'(err_flag), 32'h0);
        chk("R1 sd_out", 32'(sd_out), 32'h0);

        // ---- framed receive ----
        host_wr(8'h55);
        chk("R3 write ignored in rx", 32'(buf_stat), 32'h0);
        host_rd(got);
        chk("R2 read on empty", 32'(buf_stat), 32'h0);
        send_bits(8'hFF, 0, 0, W-1);
        chk("R5 no transfer without frame-sync", 32'(buf_stat), 32'h0);
        a = W'($urandom);
        send_bits(W'($urandom), 1, 0, 2);
        send_bits(a, 1, 0, W-1);
        chk("R5 aborted word not stored", 32'(buf_stat), 32'h2);
        chk("R3 rx word", 32'(rd_data), 32'(a));
        b = W'($urandom);
        send_bits(b, 1, 0, W-1);
        chk("R2 full code", 32'(buf_stat), 32'h3);
        chk("R8 no error before overflow", 32'(err_flag), 32'h0);
        c = W'($urandom);
        send_bits(c, 1, 0, 0);
        chk("R8 error at frame-sync while full", 32'(err_flag), 32'h1);
        send_bits(c, 0, 1, W-1);
        chk("R10 stays full", 32'(buf_stat), 32'h3);
        host_rd(got);
        chk("R10 oldest discarded", 32'(got), 32'(b));
        chk("R2 partial code", 32'(buf_stat), 32'h2);
        host_rd(got);
        chk("R10 new word kept", 32'(got), 32'(c));
        chk("R2 empty code", 32'(buf_stat), 32'h0);
        chk("R11 flag sticky", 32'(err_flag), 32'h1);
        clear_err();
        chk("R11 flag cleared", 32'(err_flag), 32'h0);
        for (int k = 0; k < 3; k++) send_bits(W'($urandom), 1, 0, W-1);
        chk("R8 refill error", 32'(err_flag), 32'h1);

        // ---- framed transmit ----
        set_mode(1'b1, 1'b1);
        chk("R12 flush on direction change", 32'(buf_stat), 32'h0);
        chk("R12 flag cleared on direction change", 32'(err_flag), 32'h0);
        run_tx(1, got);
        chk("R7 zeros after flush", 32'(got), 32'h0);
        chk("R7 underflow flag", 32'(err_flag), 32'h1);
        clear_err();
        x = W'($urandom); y = W'($urandom); z = W'($urandom);
        host_wr(x); host_wr(y); host_wr(z);
        chk("R4 full after two writes", 32'(buf_stat), 32'h3);
        run_tx(1, got);
        chk("R4 first word sent", 32'(got), 32'(x));
        chk("R4 one word left", 32'(buf_stat), 32'h2);
        run_tx(0, got);
        chk("R5 idle ticks send zeros", 32'(got), 32'h0);
        chk("R5 idle ticks pop nothing", 32'(buf_stat), 32'h2);
        host_rd(got);
        chk("R4 read ignored in tx", 32'(buf_stat), 32'h2);
        run_tx(1, got);
        chk("R4 write to full dropped", 32'(got), 32'(y));
        chk("R4 drained", 32'(buf_stat), 32'h0);
        chk("R7 no underflow yet", 32'(err_flag), 32'h0);
        run_tx(1, got);
        chk("R7 repeat last word", 32'(got), 32'(y));
        chk("R7 underflow flag set", 32'(err_flag), 32'h1);
        clear_err();

        last = y; merr = 1'b0;
        for (int it = 0; it < 30; it++) begin
            int nw;
            nw = int'($urandom % 3);
            for (int j = 0; j < nw; j++) begin
                d = W'($urandom);
                host_wr(d);
                if (mq.size() < 2) mq.push_back(d);
            end
            if ($urandom % 4 == 0) begin
                clear_err();
                merr = 1'b0;
            end
            run_tx(1, got);
            if (mq.size() > 0) exp = mq.pop_front();
            else begin
                exp = last;
                merr = 1'b1;
            end
            last = exp;
            chk("R4 random tx word", 32'(got), 32'(exp));
            chk("R7 random tx flag", 32'(err_flag), 32'(merr));
            chk("R2 random tx code", 32'(buf_stat), 32'(enc(mq.size())));
        end

        // ---- free-running transmit ----
        set_mode(1'b1, 1'b0);
        chk("R12 flush on framing change", 32'(buf_stat), 32'h0);
        chk("R12 flag cleared on framing change", 32'(err_flag), 32'h0);
        mq.delete();
        a = W'($urandom); b = W'($urandom);
        host_wr(a); host_wr(b);
        run_tx(2, got);
        chk("R6 first back-to-back word", 32'(got), 32'(a));
        run_tx(2, got);
        chk("R6 second back-to-back word", 32'(got), 32'(b));
        chk("R6 no underflow", 32'(err_flag), 32'h0);
        run_tx(2, got);
        chk("R7 free-running repeat", 32'(got), 32'(b));
        chk("R7 free-running underflow", 32'(err_flag), 32'h1);

        // ---- free-running receive ----
        set_mode(1'b0, 1'b0);
        chk("R12 flush into receive", 32'(buf_stat), 32'h0);
        merr = 1'b0;
        for (int it = 0; it < 40; it++) begin
            int nr;
            d = W'($urandom);
            send_bits(d, 2, 0, W-1);
            if (mq.size() == 2) begin
                void'(mq.pop_front());
                merr = 1'b1;
            end
            mq.push_back(d);
            chk("R9 random rx flag", 32'(err_flag), 32'(merr));
            chk("R2 random rx code", 32'(buf_stat), 32'(enc(mq.size())));
            nr = int'($urandom % 3);
            for (int j = 0; j < nr; j++) begin
                host_rd(got);
                if (mq.size() > 0) begin
                    exp = mq.pop_front();
                    chk("R3 random rx word", 32'(got), 32'(exp));
                end
            end
            if ($urandom % 5 == 0) begin
                clear_err();
                merr = 1'b0;
                chk("R11 random clear", 32'(err_flag), 32'h0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule